// File: doc/BRIEF.md
# BCD Real-Time Clock Register File with Snapshot Bank

This block is the timekeeping core of a real-time clock. A set of internal BCD counters tracks seconds, minutes, hours, day of week, date, month, year and century in 24-hour form. A one-cycle `tick` pulse stands in for the prescaled once-per-second oscillator event. Software does not see the counters directly. It reads and writes a second bank of user copies through a small parallel register bus. On every accepted tick, all user copies are refreshed together from the incremented counters.

A control register holds two halt bits. With READ set, software can read a stable time while the counters keep running. With WRITE set, software can load a new time into the user copies. Clearing WRITE then commits every user time field into the counters in a single cycle. A STOP bit, in the top bit of the seconds register, makes the core ignore ticks. Reset brings up a defined calendar point with both halt bits cleared.

Top module: `rtc_snapshot_regs`

## Requirements
- R1: After reset the registers read as follows. Control reads 0x00. Seconds reads 0x00, with STOP clear. Minutes reads 0x00 and hours reads 0x00. Day of week reads 0x01, date 0x01 and month 0x01. Year reads 0x00 and century reads 0x20.
- R2: The register map is as follows. Address 0 is control: bit 7 is WRITE, bit 6 is READ, and the other bits read 0. Address 1 is seconds: bit 7 is STOP and bits 6:0 hold BCD seconds. Address 2 is minutes, 3 is hours (00 to 23), 4 is day of week (1 to 7), 5 is date, 6 is month, 7 is year and 8 is century. Addresses 9 to 15 read 0x00, and writes to them change nothing.
- R3: A tick with STOP, READ and WRITE all clear refreshes every user copy with the incremented time. Read data follows the address combinationally, so the new value is readable in the cycle after the tick.
- R4: While READ is 1, ticks leave the user copies unchanged, but the counters still advance. After READ is cleared, the next tick shows the time advanced by every tick since the halt began.
- R5: A control write that sets READ or WRITE in the same cycle as a tick does not suppress that tick's refresh.
- R6: While WRITE is 1, ticks do not refresh the user copies. Bus writes to time registers land in the user copies and read back.
- R7: A control write that clears WRITE while it is 1 copies every user time field into the counters in one cycle. A tick in that same cycle is discarded. The next tick shows the loaded time plus one second.
- R8: With STOP at 1, ticks change neither the counters nor the user copies. Writing STOP back to 0 resumes counting at the next tick.
- R9: On a tick, 23:59:59 rolls to 00:00:00 and the date advances. Day of week advances, wrapping from 7 to 1.
- R10: The last date of a month is 30 for April, June, September and November, and 31 for the other long months. February ends on the 28th, or on the 29th when the BCD year is divisible by 4. December 31 rolls to January 1 of the next year. Year 99 rolls to 00 and increments the century.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | One-cycle once-per-second step pulse |
| addr | input | ADDR_W | Register address |
| wr_en | input | 1 | Write strobe for the addressed register |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data of the addressed register, combinational |

## Verification
Two pairs of events can fall in the same cycle. The first is a control write and an accepted tick. The bench provokes this by raising `wr_en` to the control address and `tick` on the same clock edge, once in each of two situations. In the first, the write sets READ. That tick's refresh must still be visible, and later ticks must not be. In the second, the write clears WRITE. The committed time must show no trace of that tick, and the following tick must give exactly the loaded time plus one second.

// File: rtl/rtc_regs_pkg.sv
// Package: shared time record, register addresses and BCD calendar helpers.
// Assumes every stored field holds valid packed BCD.
package rtc_regs_pkg;

    typedef struct packed {
        logic [7:0] cent;
        logic [7:0] year;
        logic [7:0] month;
        logic [7:0] date;
        logic [7:0] day;
        logic [7:0] hour;
        logic [7:0] min;
        logic [7:0] sec;
    } rtc_time_t;

    localparam int A_CTRL  = 0;
    localparam int A_SEC   = 1;
    localparam int A_MIN   = 2;
    localparam int A_HOUR  = 3;
    localparam int A_DAY   = 4;
    localparam int A_DATE  = 5;
    localparam int A_MONTH = 6;
    localparam int A_YEAR  = 7;
    localparam int A_CENT  = 8;

    // Increment a two-digit BCD value, wrapping 99 to 00.
    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        if (v == 8'h99)
            return 8'h00;
        else if (v[3:0] == 4'h9)
            return {v[7:4] + 4'h1, 4'h0};
        else
            return v + 8'h01;
    endfunction

    // Leap test on a BCD year: 10 is 2 mod 4, so check (2*tens + ones) mod 4.
    function automatic logic is_leap(input logic [7:0] y);
        logic [5:0] s;
        s = {1'b0, y[7:4], 1'b0} + {2'b00, y[3:0]};
        return (s[1:0] == 2'b00);
    endfunction

    // Last date of a month, in BCD.
    function automatic logic [7:0] month_last(input logic [7:0] m, input logic [7:0] y);
        case (m)
            8'h02:                      return is_leap(y) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

endpackage

// File: rtl/rtc_time_counter.sv
// Module: running BCD calendar counters.
// Steps once per accepted tick, loads a whole time record in one cycle on commit.
// Assumes load and step are never both high (the top gives load priority).
module rtc_time_counter
    import rtc_regs_pkg::*;
#(
    parameter logic [7:0] RESET_CENT = 8'h20
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      step_i,
    input  logic      load_i,
    input  rtc_time_t load_val_i,
    output rtc_time_t cnt_o,
    output rtc_time_t next_o
);

    rtc_time_t cnt_q;
    rtc_time_t nxt;

    // Next calendar value, one second later.
    always_comb begin
        nxt = cnt_q;
        if (cnt_q.sec != 8'h59) begin
            nxt.sec = bcd_inc(cnt_q.sec);
        end else begin
            nxt.sec = 8'h00;
            if (cnt_q.min != 8'h59) begin
                nxt.min = bcd_inc(cnt_q.min);
            end else begin
                nxt.min = 8'h00;
                if (cnt_q.hour != 8'h23) begin
                    nxt.hour = bcd_inc(cnt_q.hour);
                end else begin
                    nxt.hour = 8'h00;
                    nxt.day  = (cnt_q.day == 8'h07) ? 8'h01 : bcd_inc(cnt_q.day);
                    if (cnt_q.date != month_last(cnt_q.month, cnt_q.year)) begin
                        nxt.date = bcd_inc(cnt_q.date);
                    end else begin
                        nxt.date = 8'h01;
                        if (cnt_q.month != 8'h12) begin
                            nxt.month = bcd_inc(cnt_q.month);
                        end else begin
                            nxt.month = 8'h01;
                            nxt.year  = bcd_inc(cnt_q.year);
                            if (cnt_q.year == 8'h99)
                                nxt.cent = bcd_inc(cnt_q.cent);
                        end
                    end
                end
            end
        end
    end

    // Counter register: reset point, commit load, or one-second step.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '{cent: RESET_CENT, year: 8'h00, month: 8'h01, date: 8'h01,
                       day: 8'h01, hour: 8'h00, min: 8'h00, sec: 8'h00};
        else if (load_i)
            cnt_q <= load_val_i;
        else if (step_i)
            cnt_q <= nxt;
    end

    assign cnt_o  = cnt_q;
    assign next_o = nxt;

    assert_commit_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (cnt_q == $past(load_val_i)));

    assert_hour_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !load_i && cnt_q.hour == 8'h23 && cnt_q.min == 8'h59 && cnt_q.sec == 8'h59)
        |=> (cnt_q.hour == 8'h00 && cnt_q.min == 8'h00 && cnt_q.sec == 8'h00));

endmodule

// File: rtl/rtc_user_bank.sv
// Module: user-visible copies of the time fields.
// A refresh overwrites all fields at once and takes priority over a bus write.
// Assumes wr_sel_i is a valid time address (1..8) whenever wr_i is high.
module rtc_user_bank
    import rtc_regs_pkg::*;
#(
    parameter int         ADDR_W     = 4,
    parameter logic [7:0] RESET_CENT = 8'h20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              refresh_i,
    input  rtc_time_t         refresh_val_i,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] wr_sel_i,
    input  logic [7:0]        wr_data_i,
    output rtc_time_t         bank_o
);

    rtc_time_t bank_q;

    // Bank register: reset point, full refresh, or a single masked field write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_q <= '{cent: RESET_CENT, year: 8'h00, month: 8'h01, date: 8'h01,
                        day: 8'h01, hour: 8'h00, min: 8'h00, sec: 8'h00};
        end else if (refresh_i) begin
            bank_q <= refresh_val_i;
        end else if (wr_i) begin
            case (int'(wr_sel_i))
                A_SEC:   bank_q.sec   <= wr_data_i & 8'h7F;
                A_MIN:   bank_q.min   <= wr_data_i & 8'h7F;
                A_HOUR:  bank_q.hour  <= wr_data_i & 8'h3F;
                A_DAY:   bank_q.day   <= wr_data_i & 8'h07;
                A_DATE:  bank_q.date  <= wr_data_i & 8'h3F;
                A_MONTH: bank_q.month <= wr_data_i & 8'h1F;
                A_YEAR:  bank_q.year  <= wr_data_i;
                A_CENT:  bank_q.cent  <= wr_data_i;
                default: ;
            endcase
        end
    end

    assign bank_o = bank_q;

    assert_bank_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!refresh_i && !wr_i) |=> $stable(bank_q));

endmodule

// File: rtl/rtc_ctrl.sv
// Module: READ / WRITE halt bits and the STOP bit.
// Produces a one-cycle commit when a control write clears a set WRITE bit.
module rtc_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic ctrl_wr_i,
    input  logic wbit_i,
    input  logic rbit_i,
    input  logic sec_wr_i,
    input  logic stop_bit_i,
    output logic read_q,
    output logic write_q,
    output logic stop_q,
    output logic commit_o
);

    // Halt bits follow control writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            read_q  <= 1'b0;
            write_q <= 1'b0;
        end else if (ctrl_wr_i) begin
            read_q  <= rbit_i;
            write_q <= wbit_i;
        end
    end

    // STOP follows the top bit of each seconds write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            stop_q <= 1'b0;
        else if (sec_wr_i)
            stop_q <= stop_bit_i;
    end

    assign commit_o = ctrl_wr_i && write_q && !wbit_i;

    assert_commit_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        commit_o |=> !write_q);

endmodule

// File: rtl/rtc_snapshot_regs.sv
// Module: top of the BCD real-time clock register file.
// Ties the running counters to the user bank, decodes the bus and muxes read data.
// Assumes tick is a single-cycle pulse at most once per second.
module rtc_snapshot_regs
    import rtc_regs_pkg::*;
#(
    parameter int         ADDR_W     = 4,
    parameter logic [7:0] RESET_CENT = 8'h20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [7:0]        wr_data,
    output logic [7:0]        rd_data
);

    localparam int LAST_TIME_A = A_CENT;

    rtc_time_t cnt, nxt, bank;
    logic      read_q, write_q, stop_q, commit;
    logic      ctrl_wr, sec_wr, time_wr, step, refresh;

    assign ctrl_wr = wr_en && (int'(addr) == A_CTRL);
    assign sec_wr  = wr_en && (int'(addr) == A_SEC);
    assign time_wr = wr_en && (int'(addr) >= A_SEC) && (int'(addr) <= LAST_TIME_A);
    assign step    = tick && !stop_q && !commit;
    assign refresh = step && !read_q && !write_q;

    rtc_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_wr_i  (ctrl_wr),
        .wbit_i     (wr_data[7]),
        .rbit_i     (wr_data[6]),
        .sec_wr_i   (sec_wr),
        .stop_bit_i (wr_data[7]),
        .read_q     (read_q),
        .write_q    (write_q),
        .stop_q     (stop_q),
        .commit_o   (commit)
    );

    rtc_time_counter #(.RESET_CENT(RESET_CENT)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .step_i     (step),
        .load_i     (commit),
        .load_val_i (bank),
        .cnt_o      (cnt),
        .next_o     (nxt)
    );

    rtc_user_bank #(.ADDR_W(ADDR_W), .RESET_CENT(RESET_CENT)) u_bank (
        .clk           (clk),
        .rst_n         (rst_n),
        .refresh_i     (refresh),
        .refresh_val_i (nxt),
        .wr_i          (time_wr),
        .wr_sel_i      (addr),
        .wr_data_i     (wr_data),
        .bank_o        (bank)
    );

    // Read data multiplexer over the register map.
    always_comb begin
        case (int'(addr))
            A_CTRL:  rd_data = {write_q, read_q, 6'b0};
            A_SEC:   rd_data = {stop_q, bank.sec[6:0]};
            A_MIN:   rd_data = bank.min;
            A_HOUR:  rd_data = bank.hour;
            A_DAY:   rd_data = bank.day;
            A_DATE:  rd_data = bank.date;
            A_MONTH: rd_data = bank.month;
            A_YEAR:  rd_data = bank.year;
            A_CENT:  rd_data = bank.cent;
            default: rd_data = 8'h00;
        endcase
    end

    assert_refresh_copy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        refresh |=> (bank == cnt));

    assert_halt_refresh_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && tick && !stop_q && !read_q && !write_q) |=> (bank == cnt));

    assert_stop_freeze_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_q && !commit) |=> $stable(cnt));

endmodule

// File: tb/test_rtc_snapshot_regs.sv
module test_rtc_snapshot_regs;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic [3:0] addr = 4'd0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    rtc_snapshot_regs i_rtc_snapshot_regs (
        .clk(clk), .rst_n(rst_n), .tick(tick), .addr(addr),
        .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data)
    );

    task automatic chk(input logic [3:0] a, input logic [7:0] exp, input string tag);
        addr = a;
        #1;
        checks++;
        if (rd_data !== exp) begin
            errors++;
            $display("FAIL %s addr %0d actual %h expected %h", tag, a, rd_data, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wr_tick(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1; tick = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; tick = 1'b0;
    endtask

    task automatic pulse(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
        end
    endtask

    task automatic set_time(input logic [7:0] ce, yr, mo, dt, dy, hr, mn, sc);
        wr(4'd0, 8'h80);
        wr(4'd8, ce); wr(4'd7, yr); wr(4'd6, mo); wr(4'd5, dt);
        wr(4'd4, dy); wr(4'd3, hr); wr(4'd2, mn); wr(4'd1, sc);
        wr(4'd0, 8'h00);
    endtask

    task automatic t_reset;
        chk(4'd0, 8'h00, "R1 ctrl");
        chk(4'd1, 8'h00, "R1 sec");
        chk(4'd2, 8'h00, "R1 min");
        chk(4'd3, 8'h00, "R1 hour");
        chk(4'd4, 8'h01, "R1 day");
        chk(4'd5, 8'h01, "R1 date");
        chk(4'd6, 8'h01, "R1 month");
        chk(4'd7, 8'h00, "R1 year");
        chk(4'd8, 8'h20, "R1 cent");
    endtask

    task automatic t_map;
        wr(4'd9, 8'hFF);
        wr(4'd15, 8'hFF);
        chk(4'd9, 8'h00, "R2 unused reads 0");
        chk(4'd15, 8'h00, "R2 unused reads 0");
        chk(4'd0, 8'h00, "R2 ctrl untouched");
        chk(4'd8, 8'h20, "R2 cent untouched");
        wr(4'd0, 8'h7F);
        chk(4'd0, 8'h40, "R2 ctrl low bits read 0");
        wr(4'd0, 8'h00);
    endtask

    task automatic t_tick;
        pulse(1);
        chk(4'd1, 8'h01, "R3 sec after tick");
        pulse(9);
        chk(4'd1, 8'h10, "R3 sec BCD carry");
    endtask

    task automatic t_read_halt;
        set_time(8'h20, 8'h25, 8'h06, 8'h15, 8'h03, 8'h12, 8'h34, 8'h56);
        chk(4'd1, 8'h56, "R7 bank after commit");
        wr(4'd0, 8'h40);
        pulse(3);
        chk(4'd1, 8'h56, "R4 sec frozen");
        chk(4'd2, 8'h34, "R4 min frozen");
        wr(4'd0, 8'h00);
        chk(4'd1, 8'h56, "R4 no refresh at clear");
        pulse(1);
        chk(4'd1, 8'h00, "R4 sec counters ran");
        chk(4'd2, 8'h35, "R4 min counters ran");
    endtask

    task automatic t_halt_same_cycle;
        set_time(8'h20, 8'h25, 8'h06, 8'h15, 8'h03, 8'h10, 8'h00, 8'h20);
        wr_tick(4'd0, 8'h40);
        chk(4'd1, 8'h21, "R5 refresh completes with READ set");
        pulse(1);
        chk(4'd1, 8'h21, "R5 halted afterwards");
        wr(4'd0, 8'h00);
        pulse(1);
        chk(4'd1, 8'h23, "R5 resumed");
    endtask

    task automatic t_write_commit;
        wr(4'd0, 8'h80);
        pulse(2);
        wr(4'd2, 8'h45);
        wr(4'd1, 8'h07);
        chk(4'd2, 8'h45, "R6 min written");
        chk(4'd1, 8'h07, "R6 sec written");
        chk(4'd0, 8'h80, "R6 WRITE reads back");
        pulse(1);
        chk(4'd1, 8'h07, "R6 no refresh under WRITE");
        wr_tick(4'd0, 8'h00);
        chk(4'd0, 8'h00, "R7 WRITE cleared");
        chk(4'd1, 8'h07, "R7 tick at commit discarded");
        pulse(1);
        chk(4'd1, 8'h08, "R7 loaded plus one sec");
        chk(4'd2, 8'h45, "R7 loaded min");
        chk(4'd3, 8'h10, "R7 loaded hour");
    endtask

    task automatic t_stop;
        set_time(8'h20, 8'h25, 8'h06, 8'h15, 8'h03, 8'h10, 8'h00, 8'hB0);
        chk(4'd1, 8'hB0, "R8 STOP set");
        pulse(2);
        chk(4'd1, 8'hB0, "R8 tick ignored");
        wr(4'd1, 8'h30);
        chk(4'd1, 8'h30, "R8 STOP cleared");
        pulse(1);
        chk(4'd1, 8'h31, "R8 resumed");
    endtask

    task automatic t_day_roll;
        set_time(8'h20, 8'h25, 8'h06, 8'h15, 8'h07, 8'h23, 8'h59, 8'h59);
        pulse(1);
        chk(4'd3, 8'h00, "R9 hour wrap");
        chk(4'd2, 8'h00, "R9 min wrap");
        chk(4'd1, 8'h00, "R9 sec wrap");
        chk(4'd4, 8'h01, "R9 day 7 to 1");
        chk(4'd5, 8'h16, "R9 date advance");
    endtask

    task automatic t_month(input logic [7:0] yr, mo, dt, exp_mo, exp_dt, input string tag);
        set_time(8'h20, yr, mo, dt, 8'h02, 8'h23, 8'h59, 8'h59);
        pulse(1);
        chk(4'd6, exp_mo, tag);
        chk(4'd5, exp_dt, tag);
        chk(4'd4, 8'h03, tag);
    endtask

    task automatic t_calendar;
        t_month(8'h24, 8'h02, 8'h28, 8'h02, 8'h29, "R10 leap Feb 28");
        t_month(8'h24, 8'h02, 8'h29, 8'h03, 8'h01, "R10 leap Feb 29");
        t_month(8'h23, 8'h02, 8'h28, 8'h03, 8'h01, "R10 common Feb 28");
        t_month(8'h23, 8'h04, 8'h30, 8'h05, 8'h01, "R10 Apr 30");
        t_month(8'h23, 8'h01, 8'h30, 8'h01, 8'h31, "R10 Jan 30");
        t_month(8'h23, 8'h01, 8'h31, 8'h02, 8'h01, "R10 Jan 31");
        t_month(8'h23, 8'h12, 8'h31, 8'h01, 8'h01, "R10 Dec 31");
        chk(4'd7, 8'h24, "R10 year advance");
        set_time(8'h20, 8'h99, 8'h12, 8'h31, 8'h05, 8'h23, 8'h59, 8'h59);
        pulse(1);
        chk(4'd7, 8'h00, "R10 year 99 wrap");
        chk(4'd8, 8'h21, "R10 century advance");
    endtask

    task automatic summary;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_map;
        t_tick;
        t_read_halt;
        t_halt_same_cycle;
        t_write_commit;
        t_stop;
        t_day_roll;
        t_calendar;
        summary;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual hung expected done");
        summary;
    end

endmodule